// File: doc/BRIEF.md
# Store Write-Data Forwarding Unit

This block chooses the write data for a store that sits in the first memory stage (M1) of a pipeline with two memory stages. A store takes its address straight from its first source register, with no offset, and its data from its second source register (rs2). The rs2 value that travelled down the pipeline with the store may be stale, because an older instruction further down may not have written its result back yet. The unit compares the store's rs2 index with the destinations held in the M1/M2 and M2/RW pipeline registers. When one of them matches, it replaces the stale value with the newer result.

A result held in M1/M2 can be forwarded only if it comes from an ALU operation, because load data is not valid until the end of M2. A result held in M2/RW can be forwarded whether it comes from a load or from the ALU. If a load in M1/M2 targets the store's rs2, the value cannot be forwarded, so the unit raises a conflict flag for the hazard logic to act on. The selected data is captured at the M1-to-M2 boundary as the memory write data, together with a write strobe.

Top module: `st_data_fwd`

## Requirements
- R1: When neither source matches, `st_wdata` equals `m1_rs2_val` and `st_sel` is 2'b00.
- R2: When `mm_wen` is 1, `mm_rd` equals `m1_rs2`, `mm_rd` is not 0 and `mm_is_load` is 0, `st_wdata` equals `mm_result` and `st_sel` is 2'b01.
- R3: When `mr_wen` is 1, `mr_rd` equals `m1_rs2` and `mr_rd` is not 0, and the M1/M2 source is not selected, `st_wdata` equals `mr_value` and `st_sel` is 2'b10. This holds whether the M2/RW producer was a load or an ALU operation.
- R4: When both sources qualify, the M1/M2 source (the younger one) wins. `st_sel` never takes the value 2'b11.
- R5: A producer whose destination is register 0 is never forwarded, from either stage.
- R6: A producer whose write enable is 0 is never forwarded, even if its destination matches.
- R7: A load in M1/M2 with a matching, nonzero destination is never forwarded. The data falls back to the M2/RW source or to `m1_rs2_val`.
- R8: `st_conflict` is 1 exactly when `m1_store` is 1 and a write-enabled load in M1/M2 has a nonzero destination equal to `m1_rs2`.
- R9: At each rising clock edge, `mem_we` becomes `m1_store` and not `st_conflict`. When it is set, `mem_wdata` takes the `st_wdata` value from that cycle. Reset clears both.
- R10: `mem_wdata` holds its value in any cycle in which no store is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m1_store | input | 1 | A store occupies M1 |
| m1_rs2 | input | AW | Data source register index of the store |
| m1_rs2_val | input | XLEN | rs2 value carried down the pipeline |
| mm_wen | input | 1 | M1/M2 producer writes a register |
| mm_rd | input | AW | M1/M2 destination index |
| mm_is_load | input | 1 | M1/M2 producer is a load |
| mm_result | input | XLEN | ALU result held in M1/M2 |
| mr_wen | input | 1 | M2/RW producer writes a register |
| mr_rd | input | AW | M2/RW destination index |
| mr_value | input | XLEN | Load data or ALU result held in M2/RW |
| st_wdata | output | XLEN | Forwarded store data (combinational) |
| st_sel | output | 2 | Source: 00 pipeline, 01 M1/M2, 10 M2/RW |
| st_conflict | output | 1 | Unforwardable load-to-store dependence |
| mem_we | output | 1 | Memory write strobe captured at M1/M2 boundary |
| mem_wdata | output | XLEN | Memory write data captured at M1/M2 boundary |

## Verification
A faulty match comparison or priority shows up at once on `st_sel` and `st_wdata`, in the same cycle the inputs are applied. No clock edge is needed. A fault in the conflict logic or the capture register shows up one edge later, as a wrong `mem_we` strobe or a stale or incorrect `mem_wdata`. Because the data operands are distinct for each source, a wrong source is visible in the data value itself and not only in the select code.

// File: rtl/st_data_fwd.sv
module st_data_fwd #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m1_store,
  input  logic [AW-1:0]   m1_rs2,
  input  logic [XLEN-1:0] m1_rs2_val,
  input  logic            mm_wen,
  input  logic [AW-1:0]   mm_rd,
  input  logic            mm_is_load,
  input  logic [XLEN-1:0] mm_result,
  input  logic            mr_wen,
  input  logic [AW-1:0]   mr_rd,
  input  logic [XLEN-1:0] mr_value,
  output logic [XLEN-1:0] st_wdata,
  output logic [1:0]      st_sel,
  output logic            st_conflict,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata
);

  logic mm_match, mm_fwd, mr_fwd, capture;

  assign mm_match = mm_wen && (mm_rd == m1_rs2) && (mm_rd != '0);
  assign mm_fwd   = mm_match && !mm_is_load;
  assign mr_fwd   = mr_wen && (mr_rd == m1_rs2) && (mr_rd != '0);

  assign st_sel   = mm_fwd ? 2'b01 : (mr_fwd ? 2'b10 : 2'b00);

  always_comb begin
    case (st_sel)
      2'b01:   st_wdata = mm_result;
      2'b10:   st_wdata = mr_value;
      default: st_wdata = m1_rs2_val;
    endcase
  end

  assign st_conflict = m1_store && mm_match && mm_is_load;
  assign capture     = m1_store && !st_conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= capture;
      if (capture) mem_wdata <= st_wdata;
    end
  end

endmodule

// File: rtl/st_data_fwd_chk.sv
module st_data_fwd_chk #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m1_store,
  input logic [AW-1:0]   m1_rs2,
  input logic [XLEN-1:0] m1_rs2_val,
  input logic            mm_wen,
  input logic [AW-1:0]   mm_rd,
  input logic            mm_is_load,
  input logic [XLEN-1:0] mm_result,
  input logic [XLEN-1:0] mr_value,
  input logic [XLEN-1:0] st_wdata,
  input logic [1:0]      st_sel,
  input logic            st_conflict,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_wdata
);

  p_src_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel == 2'b00 |-> st_wdata == m1_rs2_val);

  p_src_mm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel == 2'b01 |-> st_wdata == mm_result && !mm_is_load && mm_wen);

  p_src_mr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel == 2'b10 |-> st_wdata == mr_value);

  p_legal_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel != 2'b11);

  p_no_x0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_sel != 2'b00 |-> m1_rs2 != '0);

  p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_conflict |-> m1_store && mm_is_load && mm_wen && mm_rd == m1_rs2);

  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m1_store && !st_conflict |=> mem_we && mem_wdata == $past(st_wdata));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_store || st_conflict |=> !mem_we);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_store |=> $stable(mem_wdata));

endmodule

bind st_data_fwd st_data_fwd_chk #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .m1_store(m1_store), .m1_rs2(m1_rs2),
  .m1_rs2_val(m1_rs2_val), .mm_wen(mm_wen), .mm_rd(mm_rd),
  .mm_is_load(mm_is_load), .mm_result(mm_result), .mr_value(mr_value),
  .st_wdata(st_wdata), .st_sel(st_sel), .st_conflict(st_conflict),
  .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/st_data_fwd_test.sv
module st_data_fwd_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int AW = 5;

  localparam logic [XLEN-1:0] VP = 32'h1111_0000;
  localparam logic [XLEN-1:0] VM = 32'h2222_0000;
  localparam logic [XLEN-1:0] VR = 32'h3333_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m1_store = 0, mm_wen = 0, mm_is_load = 0, mr_wen = 0;
  logic [AW-1:0] m1_rs2 = '0, mm_rd = '0, mr_rd = '0;
  logic [XLEN-1:0] m1_rs2_val = '0, mm_result = '0, mr_value = '0;
  logic [XLEN-1:0] st_wdata, mem_wdata;
  logic [1:0] st_sel;
  logic st_conflict, mem_we;

  int total = 0, failed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  st_data_fwd uut (
    .clk(clk), .rst_n(rst_n), .m1_store(m1_store), .m1_rs2(m1_rs2),
    .m1_rs2_val(m1_rs2_val), .mm_wen(mm_wen), .mm_rd(mm_rd),
    .mm_is_load(mm_is_load), .mm_result(mm_result), .mr_wen(mr_wen),
    .mr_rd(mr_rd), .mr_value(mr_value), .st_wdata(st_wdata),
    .st_sel(st_sel), .st_conflict(st_conflict), .mem_we(mem_we),
    .mem_wdata(mem_wdata)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [AW-1:0] rs2,
                       input logic mw, input logic [AW-1:0] mrd, input logic ml,
                       input logic rw, input logic [AW-1:0] rrd,
                       input logic [XLEN-1:0] tag);
    @(negedge clk);
    m1_store = st; m1_rs2 = rs2; m1_rs2_val = VP ^ tag;
    mm_wen = mw; mm_rd = mrd; mm_is_load = ml; mm_result = VM ^ tag;
    mr_wen = rw; mr_rd = rrd; mr_value = VR ^ tag;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 0;
    drive(1, 5'd3, 0, 0, 0, 0, 0, 32'h1);
    @(posedge clk); #1;
    check("R9 reset we", {31'b0, mem_we}, 32'b0);
    check("R9 reset data", mem_wdata, 32'b0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_no_match;
    drive(1, 5'd4, 1, 5'd6, 0, 1, 5'd7, 32'h10);
    check("R1 data", st_wdata, VP ^ 32'h10);
    check("R1 sel", {30'b0, st_sel}, 32'd0);
  endtask

  task automatic t_mm_fwd;
    drive(1, 5'd9, 1, 5'd9, 0, 0, 5'd9, 32'h20);
    check("R2 data", st_wdata, VM ^ 32'h20);
    check("R2 sel", {30'b0, st_sel}, 32'd1);
    check("R2 no conflict", {31'b0, st_conflict}, 32'd0);
  endtask

  task automatic t_mr_fwd;
    drive(1, 5'd12, 0, 5'd12, 0, 1, 5'd12, 32'h30);
    check("R3 alu data", st_wdata, VR ^ 32'h30);
    check("R3 sel", {30'b0, st_sel}, 32'd2);
    drive(1, 5'd12, 1, 5'd13, 1, 1, 5'd12, 32'h31);
    check("R3 load data", st_wdata, VR ^ 32'h31);
  endtask

  task automatic t_priority;
    drive(1, 5'd31, 1, 5'd31, 0, 1, 5'd31, 32'h40);
    check("R4 younger wins", st_wdata, VM ^ 32'h40);
    check("R4 sel", {30'b0, st_sel}, 32'd1);
  endtask

  task automatic t_x0;
    drive(1, 5'd0, 1, 5'd0, 0, 1, 5'd0, 32'h50);
    check("R5 x0 data", st_wdata, VP ^ 32'h50);
    check("R5 x0 sel", {30'b0, st_sel}, 32'd0);
  endtask

  task automatic t_wen_off;
    drive(1, 5'd8, 0, 5'd8, 0, 0, 5'd8, 32'h60);
    check("R6 wen off data", st_wdata, VP ^ 32'h60);
  endtask

  task automatic t_load_conflict;
    drive(1, 5'd5, 1, 5'd5, 1, 1, 5'd5, 32'h70);
    check("R7 load not forwarded", st_wdata, VR ^ 32'h70);
    check("R8 conflict", {31'b0, st_conflict}, 32'd1);
    @(posedge clk); #1;
    check("R9 no write on conflict", {31'b0, mem_we}, 32'd0);
    drive(0, 5'd5, 1, 5'd5, 1, 0, 5'd0, 32'h71);
    check("R8 no store no conflict", {31'b0, st_conflict}, 32'd0);
    drive(1, 5'd5, 1, 5'd0, 1, 0, 5'd0, 32'h72);
    check("R7 load to x0", {31'b0, st_conflict}, 32'd0);
  endtask

  task automatic t_capture;
    drive(1, 5'd9, 1, 5'd9, 0, 0, 5'd0, 32'h80);
    @(posedge clk); #1;
    check("R9 we", {31'b0, mem_we}, 32'd1);
    check("R9 data", mem_wdata, VM ^ 32'h80);
  endtask

  task automatic t_hold;
    drive(0, 5'd9, 0, 5'd0, 0, 1, 5'd9, 32'h90);
    @(posedge clk); #1;
    check("R10 we low", {31'b0, mem_we}, 32'd0);
    check("R10 data held", mem_wdata, VM ^ 32'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 10000);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    t_reset();
    t_no_match();
    t_mm_fwd();
    t_mr_fwd();
    t_priority();
    t_x0();
    t_wen_off();
    t_load_conflict();
    t_capture();
    t_hold();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule